// File: doc/BRIEF.md
# USB Bulk IN Endpoint Transaction Sequencer

This block runs the device side of a single bulk IN transaction for one transmit endpoint. A token decoder hands it a decoded token (IN or not, whether the device address matched, the endpoint number). The sequencer then decides how to answer. It stays silent on a token that is not for it. It sends a STALL handshake when the endpoint is halted and a NAK handshake when no packet is ready. Otherwise it streams a data packet to the serial interface engine: a DATA0 or DATA1 PID chosen by the endpoint's toggle bit, the payload read from the endpoint FIFO, and a CRC16. After the packet it waits a bounded number of bit times for the host's ACK.

On an ACK, the block tells the FIFO to clear and drops the packet-ready flag. It also flips the data toggle and marks the endpoint READY. On a timeout, it marks the endpoint TX_ERR and rewinds the FIFO read pointer to the start of the packet. The toggle and the FIFO contents are kept, so the next IN token sends the same packet again. When a packet is larger than the endpoint's maximum payload, the transfer is refused and the endpoint is halted.

The byte stream to the serial engine is valid/ready. Once `tx_valid` is high, the block keeps it high and holds `tx_data` and `tx_last` unchanged until a cycle in which `tx_ready` is also high. The byte is taken on that clock edge. The sink may hold `tx_ready` low for any number of cycles. The FIFO is read through `fifo_rd_ptr`, and `fifo_rdata` must show the byte at that pointer in the same cycle. The first byte of a packet is at pointer 0.

Top module: `usb_bulk_in_seq`

## Requirements
- R1: A token pulse is ignored, with no byte sent and no state change, unless it is an IN token, the address matched, the endpoint number equals the block's endpoint id, and the endpoint is configured for IN (`ep_dir_in`=1).
- R2: On an accepted token while the status is STALL (code 1), exactly one byte 0x1E is sent with `tx_last` set.
- R3: On an accepted token while no packet is ready, exactly one byte 0x5A is sent with `tx_last` set.
- R4: On an accepted token with a packet ready, the block sends a PID and then `fifo_count` payload bytes read from pointers 0, 1, 2 and so on, in order. The PID is 0xC3 when the toggle is 0 and 0x4B when it is 1.
- R5: The payload is followed by the CRC16 of the payload bytes, low byte first, with `tx_last` on the high byte. The CRC uses polynomial x^16+x^15+x^2+1, processes bits LSB first, starts from all ones, and is complemented before sending. A ready packet with a count of zero sends the PID, then 0x00, then 0x00.
- R6: If the count exceeds MAX_PKT, the block sends a single 0x1E byte instead of data, pulses `ovf_err` for one cycle and sets the status to STALL. A count equal to MAX_PKT is sent normally.
- R7: An `rx_ack` while waiting for the handshake pulses `fifo_clr` in the next cycle. In that same cycle the packet-ready flag is clear, the toggle is inverted, the status is READY (0) and the read pointer is 0.
- R8: After 18 `bit_tick` strobes with no ACK, the status becomes TX_ERR (code 2) and the read pointer returns to 0. The toggle and the packet-ready flag are unchanged. After 17 strobes nothing has changed yet. The next token sends the same bytes again.
- R9: An `rx_ack` in the same cycle as the 18th strobe counts as an ACK, not a timeout.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R11: After reset the toggle is 0, the status is READY, the packet-ready flag is clear and no byte is offered. An `ep_cfg` pulse sets the toggle to 0 and the status to READY.
- R12: Tokens that arrive while a transaction is in progress, including the handshake wait, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | One-cycle pulse: a decoded token is present |
| tok_is_in | input | 1 | The token is an IN token |
| tok_addr_ok | input | 1 | The token address matched the device |
| tok_ep | input | 4 | Endpoint number carried by the token |
| ep_dir_in | input | 1 | Endpoint is configured for IN transfers |
| ep_cfg | input | 1 | Endpoint configure pulse: toggle to 0, status to READY |
| pkt_set | input | 1 | Pulse: a full packet has been loaded into the FIFO |
| fifo_count | input | CNT_W | Number of bytes in the FIFO packet |
| fifo_rdata | input | 8 | FIFO byte at `fifo_rd_ptr` |
| fifo_rd_ptr | output | CNT_W | FIFO read pointer |
| fifo_clr | output | 1 | One-cycle pulse: empty the FIFO |
| tx_valid | output | 1 | Byte offered to the serial engine |
| tx_ready | input | 1 | Serial engine accepts the byte |
| tx_data | output | 8 | Byte to transmit |
| tx_last | output | 1 | Final byte of the packet |
| rx_ack | input | 1 | ACK handshake received from the host |
| bit_tick | input | 1 | One strobe per bit time |
| ep_status | output | 2 | 0 READY, 1 STALL, 2 TX_ERR |
| data_toggle | output | 1 | Current data toggle (0 selects DATA0) |
| pkt_ready | output | 1 | A packet is ready to send |
| ovf_err | output | 1 | One-cycle pulse: packet exceeded MAX_PKT |

## Verification
Two functions can fall in the same cycle: the host's ACK and the final bit-time strobe that would end the handshake wait. The bench provokes this by giving exactly 17 strobes after a retransmitted packet. It then drives `rx_ack` and the 18th strobe together in one cycle. The outcome is judged by the ports: `fifo_clr` must pulse, the status must read READY rather than TX_ERR, and the toggle must flip. A second overlap, `pkt_set` arriving together with the ACK, is covered by the rule that the ACK's clear wins.

// File: rtl/usbin_pkg.sv
package usbin_pkg;

  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam logic [7:0] PID_STALL = 8'h1E;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_STALL = 2'd1,
    ST_TXERR = 2'd2
  } ep_stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HS,
    S_PID,
    S_DATA,
    S_CRCL,
    S_CRCH,
    S_WAIT
  } seq_state_e;

  // One byte through the reflected CRC16 (0x8005 reversed = 0xA001), LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/usbin_crc16.sv
module usbin_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_out
);
  import usbin_pkg::*;

  logic [15:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= 16'hFFFF;
    else if (init) acc <= 16'hFFFF;
    else if (en)   acc <= crc16_step(acc, din);
  end

  // Transmitted form is the ones' complement of the running register.
  assign crc_out = ~acc;
endmodule

// File: rtl/usbin_hs_timer.sv
module usbin_hs_timer #(
  parameter int TMO_BITS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic fire
);
  localparam int TW = $clog2(TMO_BITS + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO_BITS - 1);

  logic [TW-1:0] cnt;

  assign fire = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (fire)        cnt <= '0;
    else if (tick)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/usbin_ep_state.sv
module usbin_ep_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg,
  input  logic       pkt_set,
  input  logic       ack_done,
  input  logic       tmo_done,
  input  logic       ovf,
  output logic       toggle,
  output logic [1:0] status,
  output logic       ready
);
  import usbin_pkg::*;

  ep_stat_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle <= 1'b0;
      st     <= ST_READY;
      ready  <= 1'b0;
    end else begin
      if (cfg)           toggle <= 1'b0;
      else if (ack_done) toggle <= ~toggle;

      if (cfg)           st <= ST_READY;
      else if (ovf)      st <= ST_STALL;
      else if (ack_done) st <= ST_READY;
      else if (tmo_done) st <= ST_TXERR;

      // A completed transfer empties the FIFO, so its clear beats a new load.
      if (ack_done)      ready <= 1'b0;
      else if (pkt_set)  ready <= 1'b1;
    end
  end

  assign status = st;
endmodule

// File: rtl/usb_bulk_in_seq.sv
module usb_bulk_in_seq #(
  parameter int          CNT_W    = 8,
  parameter int          MAX_PKT  = 64,
  parameter int          TMO_BITS = 18,
  parameter logic [3:0]  EP_ID    = 4'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic             tok_is_in,
  input  logic             tok_addr_ok,
  input  logic [3:0]       tok_ep,
  input  logic             ep_dir_in,
  input  logic             ep_cfg,
  input  logic             pkt_set,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [7:0]       fifo_rdata,
  output logic [CNT_W-1:0] fifo_rd_ptr,
  output logic             fifo_clr,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             rx_ack,
  input  logic             bit_tick,
  output logic [1:0]       ep_status,
  output logic             data_toggle,
  output logic             pkt_ready,
  output logic             ovf_err
);
  import usbin_pkg::*;

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PKT);

  seq_state_e       state;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] sent;
  logic [7:0]       hs_pid;
  logic [15:0]      crc_val;
  logic             tok_hit, xfer, tmo_fire;
  logic             ack_done, tmo_done, ovf_now;
  logic             crc_init, crc_en;

  assign tok_hit = tok_valid && (state == S_IDLE) && tok_is_in && tok_addr_ok &&
                   (tok_ep == EP_ID) && ep_dir_in;
  assign xfer    = tx_valid && tx_ready;

  assign ovf_now  = tok_hit && (ep_status != ST_STALL) && pkt_ready && (fifo_count > MAX_CNT);
  assign ack_done = (state == S_WAIT) && rx_ack;
  assign tmo_done = (state == S_WAIT) && !rx_ack && tmo_fire;
  assign crc_init = (state == S_PID) && xfer;
  assign crc_en   = (state == S_DATA) && xfer;

  usbin_ep_state u_ep (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (ep_cfg),
    .pkt_set  (pkt_set),
    .ack_done (ack_done),
    .tmo_done (tmo_done),
    .ovf      (ovf_now),
    .toggle   (data_toggle),
    .status   (ep_status),
    .ready    (pkt_ready)
  );

  usbin_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (crc_init),
    .en      (crc_en),
    .din     (fifo_rdata),
    .crc_out (crc_val)
  );

  usbin_hs_timer #(.TMO_BITS(TMO_BITS)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == S_WAIT),
    .tick (bit_tick),
    .fire (tmo_fire)
  );

  // Byte presented to the serial engine, selected by the sequencer state.
  always_comb begin
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    tx_data  = 8'h00;
    unique case (state)
      S_HS:   begin tx_valid = 1'b1; tx_last = 1'b1; tx_data = hs_pid; end
      S_PID:  begin tx_valid = 1'b1; tx_data = data_toggle ? PID_DATA1 : PID_DATA0; end
      S_DATA: begin tx_valid = 1'b1; tx_data = fifo_rdata; end
      S_CRCL: begin tx_valid = 1'b1; tx_data = crc_val[7:0]; end
      S_CRCH: begin tx_valid = 1'b1; tx_last = 1'b1; tx_data = crc_val[15:8]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      len         <= '0;
      sent        <= '0;
      hs_pid      <= PID_NAK;
      fifo_rd_ptr <= '0;
      fifo_clr    <= 1'b0;
      ovf_err     <= 1'b0;
    end else begin
      fifo_clr <= 1'b0;
      ovf_err  <= 1'b0;
      unique case (state)
        S_IDLE: if (tok_hit) begin
          if (ep_status == ST_STALL) begin
            hs_pid <= PID_STALL;
            state  <= S_HS;
          end else if (!pkt_ready) begin
            hs_pid <= PID_NAK;
            state  <= S_HS;
          end else if (fifo_count > MAX_CNT) begin
            hs_pid  <= PID_STALL;
            ovf_err <= 1'b1;
            state   <= S_HS;
          end else begin
            len   <= fifo_count;
            state <= S_PID;
          end
        end
        S_HS: if (xfer) state <= S_IDLE;
        S_PID: if (xfer) begin
          sent  <= '0;
          state <= (len == '0) ? S_CRCL : S_DATA;
        end
        S_DATA: if (xfer) begin
          fifo_rd_ptr <= fifo_rd_ptr + 1'b1;
          sent        <= sent + 1'b1;
          if ((sent + 1'b1) == len) state <= S_CRCL;
        end
        S_CRCL: if (xfer) state <= S_CRCH;
        S_CRCH: if (xfer) state <= S_WAIT;
        S_WAIT: begin
          if (rx_ack) begin
            fifo_rd_ptr <= '0;
            fifo_clr    <= 1'b1;
            state       <= S_IDLE;
          end else if (tmo_fire) begin
            // Keep the FIFO bytes and the toggle; replay from the packet start.
            fifo_rd_ptr <= '0;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_bulk_in_seq_chk.sv
module usb_bulk_in_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             rx_ack,
  input logic             ep_cfg,
  input logic             data_toggle,
  input logic [1:0]       ep_status,
  input logic             ovf_err,
  input logic             fifo_clr,
  input logic             pkt_ready,
  input logic [CNT_W-1:0] fifo_rd_ptr
);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R6
  ovf_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !$past(ep_cfg) |-> ep_status == 2'd1);

  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_cfg && !rx_ack |=> $stable(data_toggle));

  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_status == 2'd2 && $past(ep_status) != 2'd2 |-> fifo_rd_ptr == '0);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> !pkt_ready && fifo_rd_ptr == '0);
endmodule

bind usb_bulk_in_seq usb_bulk_in_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .tx_last     (tx_last),
  .rx_ack      (rx_ack),
  .ep_cfg      (ep_cfg),
  .data_toggle (data_toggle),
  .ep_status   (ep_status),
  .ovf_err     (ovf_err),
  .fifo_clr    (fifo_clr),
  .pkt_ready   (pkt_ready),
  .fifo_rd_ptr (fifo_rd_ptr)
);

// File: tb/usb_bulk_in_seq_test.sv
module usb_bulk_in_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int MAXP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 0, tok_is_in = 0, tok_addr_ok = 0;
  logic [3:0] tok_ep = 0;
  logic ep_dir_in = 1, ep_cfg = 0, pkt_set = 0;
  logic [CNT_W-1:0] fifo_count = 0;
  logic [7:0] fifo_rdata;
  logic [CNT_W-1:0] fifo_rd_ptr;
  logic fifo_clr, tx_valid, tx_last, ovf_err, data_toggle, pkt_ready;
  logic tx_ready = 0, rx_ack = 0, bit_tick = 0;
  logic [7:0] tx_data;
  logic [1:0] ep_status;

  logic [7:0] fmem [0:15];
  logic [7:0] got  [0:31];
  logic [7:0] exp_b[0:31];
  int n_got, n_exp;
  int checks = 0, fails = 0;
  bit ovf_seen;

  assign fifo_rdata = fmem[fifo_rd_ptr[3:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_bulk_in_seq #(.CNT_W(CNT_W), .MAX_PKT(MAXP), .TMO_BITS(18), .EP_ID(4'd1)) uut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_is_in(tok_is_in),
    .tok_addr_ok(tok_addr_ok), .tok_ep(tok_ep), .ep_dir_in(ep_dir_in), .ep_cfg(ep_cfg),
    .pkt_set(pkt_set), .fifo_count(fifo_count), .fifo_rdata(fifo_rdata),
    .fifo_rd_ptr(fifo_rd_ptr), .fifo_clr(fifo_clr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .rx_ack(rx_ack),
    .bit_tick(bit_tick), .ep_status(ep_status), .data_toggle(data_toggle),
    .pkt_ready(pkt_ready), .ovf_err(ovf_err)
  );

  always @(posedge clk) if (ovf_err) ovf_seen <= 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ fmem[i][b];
        c  = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'hA001;
      end
    return ~c;
  endfunction

  task automatic build_data(input logic [7:0] pid, input int n);
    logic [15:0] c;
    c = ref_crc(n);
    exp_b[0] = pid;
    for (int i = 0; i < n; i++) exp_b[i+1] = fmem[i];
    exp_b[n+1] = c[7:0];
    exp_b[n+2] = c[15:8];
    n_exp = n + 3;
  endtask

  task automatic token(input bit is_in, input bit aok, input logic [3:0] ep);
    tok_is_in = is_in; tok_addr_ok = aok; tok_ep = ep; tok_valid = 1;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic collect(input bit bp);
    int guard = 0;
    bit stalled = 0;
    logic [7:0] held = 0;
    n_got = 0;
    while (guard < 200) begin
      if (stalled)
        check(tx_valid && tx_data == held, "R10", tx_data, held);
      tx_ready = bp ? (guard % 3 != 1) : 1'b1;
      stalled = tx_valid && !tx_ready;
      held = tx_data;
      if (tx_valid && tx_ready) begin
        got[n_got] = tx_data;
        n_got++;
        if (tx_last) begin
          @(negedge clk);
          tx_ready = 0;
          return;
        end
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 0;
  endtask

  task automatic compare(input string req);
    check(n_got == n_exp, req, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      check(got[i] == exp_b[i], req, got[i], exp_b[i]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1;
      @(negedge clk);
      bit_tick = 0;
    end
  endtask

  task automatic load(input int n);
    for (int i = 0; i < 16; i++) fmem[i] = 8'(8'h10 * i + 8'h05 + i);
    fifo_count = CNT_W'(n);
    pkt_set = 1;
    @(negedge clk);
    pkt_set = 0;
  endtask

  task automatic ack_and_check(input logic exp_tog, input string req);
    rx_ack = 1;
    @(negedge clk);
    rx_ack = 0;
    check(fifo_clr == 1'b1, req, fifo_clr, 1);
    check(pkt_ready == 1'b0, req, pkt_ready, 0);
    check(data_toggle == exp_tog, req, data_toggle, exp_tog);
    check(ep_status == 2'd0, req, ep_status, 0);
    check(fifo_rd_ptr == 0, req, fifo_rd_ptr, 0);
  endtask

  task automatic t_reset;
    check(ep_status == 0 && data_toggle == 0 && pkt_ready == 0, "R11 reset",
          {ep_status, data_toggle, pkt_ready}, 0);
    check(tx_valid == 0 && fifo_rd_ptr == 0, "R11 reset", tx_valid, 0);
  endtask

  task automatic t_nak;
    token(1, 1, 4'd1);
    collect(0);
    exp_b[0] = 8'h5A; n_exp = 1;
    compare("R3");
  endtask

  task automatic t_ignore;
    load(2);
    token(1, 1, 4'd2); check(!tx_valid, "R1 ep", tx_valid, 0);
    token(1, 0, 4'd1); check(!tx_valid, "R1 addr", tx_valid, 0);
    token(0, 1, 4'd1); check(!tx_valid, "R1 not-in", tx_valid, 0);
    ep_dir_in = 0;
    token(1, 1, 4'd1); check(!tx_valid, "R1 dir", tx_valid, 0);
    ep_dir_in = 1;
    check(fifo_rd_ptr == 0 && ep_status == 0 && pkt_ready, "R1 state", fifo_rd_ptr, 0);
  endtask

  task automatic t_data4;
    load(4);
    token(1, 1, 4'd1);
    collect(1);
    build_data(8'hC3, 4);
    compare("R4 R5 data0");
    ack_and_check(1'b1, "R7");
  endtask

  task automatic t_zlp;
    load(0);
    token(1, 1, 4'd1);
    collect(0);
    exp_b[0] = 8'h4B; exp_b[1] = 8'h00; exp_b[2] = 8'h00; n_exp = 3;
    compare("R5 zlp R4 data1");
    // pkt_set together with ACK: the clear must win (R7)
    pkt_set = 1;
    ack_and_check(1'b0, "R7 ack+pkt_set");
    pkt_set = 0;
  endtask

  task automatic t_timeout;
    load(3);
    token(1, 1, 4'd1);
    collect(0);
    build_data(8'hC3, 3);
    compare("R4 R5 three");
    ticks(17);
    check(ep_status == 0, "R8 17 ticks", ep_status, 0);
    ticks(1);
    check(ep_status == 2, "R8 status", ep_status, 2);
    check(fifo_rd_ptr == 0, "R8 rewind", fifo_rd_ptr, 0);
    check(data_toggle == 0 && pkt_ready == 1, "R8 kept", {data_toggle, pkt_ready}, 1);
    token(1, 1, 4'd1);
    collect(1);
    compare("R8 replay");
    ticks(17);
    token(1, 1, 4'd1);
    check(!tx_valid, "R12 busy token", tx_valid, 0);
    rx_ack = 1; bit_tick = 1;
    @(negedge clk);
    rx_ack = 0; bit_tick = 0;
    check(fifo_clr == 1, "R9 tie clr", fifo_clr, 1);
    check(ep_status == 0, "R9 tie status", ep_status, 0);
    check(data_toggle == 1, "R9 tie toggle", data_toggle, 1);
  endtask

  task automatic t_limits;
    load(MAXP);
    token(1, 1, 4'd1);
    collect(0);
    build_data(8'h4B, MAXP);
    compare("R6 count==max");
    ack_and_check(1'b0, "R7 max");
    ovf_seen = 0;
    load(MAXP + 1);
    token(1, 1, 4'd1);
    collect(0);
    exp_b[0] = 8'h1E; n_exp = 1;
    compare("R6 over");
    check(ovf_seen, "R6 ovf_err", ovf_seen, 1);
    check(ep_status == 1, "R6 status", ep_status, 1);
    fifo_count = 2;
    token(1, 1, 4'd1);
    collect(0);
    compare("R2 stall");
    ep_cfg = 1;
    @(negedge clk);
    ep_cfg = 0;
    check(ep_status == 0 && data_toggle == 0, "R11 cfg", {ep_status, data_toggle}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) fmem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nak();
    t_ignore();
    t_data4();
    t_zlp();
    t_timeout();
    t_limits();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule